// File: doc/BRIEF.md
# Accumulator ALU with Destination Select

This block is the execute stage of a small 8-bit accumulator machine. Each cycle it may receive one decoded operation together with a 6-bit file-register address, a destination bit and an 8-bit immediate. It holds a 64-entry file of 8-bit registers, the accumulator, and three status flags: carry (C), nibble carry (DC) and zero (Z). Every operation finishes on the clock edge on which it is presented.

Register-operand operations read the addressed file register with no delay. They send their result either to the accumulator or back to that same register, as the destination bit selects. Immediate operations always write the accumulator. Adds update all three flags. Logical AND updates only Z.

A second, read-only address port lets the surrounding logic observe any file register without disturbing an operation.

Top module: `acc_alu_top`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, all three flags and all 64 file registers to zero.
- R2: When `valid` is low, no file register, accumulator bit or flag changes on the clock edge.
- R3: Operation code 0 (register add) computes accumulator + register. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is 1 exactly when the 8-bit result is zero.
- R4: Operation code 1 (register add with carry) computes accumulator + register + C, using the C held before the edge. C, DC and Z are formed as in R3, with the carry-in included in both the low-nibble and the full sum.
- R5: Operation code 2 (immediate add) computes accumulator + immediate, always writes the accumulator, and updates C, DC and Z as in R3. The destination bit has no effect and no file register changes.
- R6: Operation codes 3 (register AND) and 4 (immediate AND) compute the bitwise AND of the accumulator with the operand and set Z from the result. C and DC keep their values.
- R7: For codes 0, 1 and 3, a destination bit of 0 writes the result to the accumulator and leaves the file unchanged. A destination bit of 1 writes the result to the addressed register and leaves the accumulator unchanged. Flags are updated in both cases.
- R8: Results and flags take effect on the same clock edge as the operation. When the result is written back to the register it was read from, the operand is that register's value before the edge.
- R9: Operation codes 5, 6 and 7 change no register, accumulator bit or flag, even with `valid` high.
- R10: `obs_data` shows the file register selected by `obs_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Qualifies the operation presented this cycle |
| op | input | 3 | Operation code (0..4 defined, 5..7 no-op) |
| reg_addr | input | 6 | File-register operand address |
| dst_sel | input | 1 | 0: result to accumulator, 1: result to file register |
| imm | input | 8 | Immediate operand |
| obs_addr | input | 6 | Observation read address |
| obs_data | output | 8 | Contents of the observed file register |
| acc | output | 8 | Accumulator |
| flag_c | output | 1 | Carry flag |
| flag_dc | output | 1 | Nibble carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
The assertions assume that `valid`, `op`, `reg_addr` and `dst_sel` are known, stable values at each rising edge. They also assume that reset is held for at least one edge before any operation is checked. The stimulus drives every input on the falling edge only, and draws operation codes from the full 3-bit range, so the undefined codes are exercised. Addresses are drawn from the full 6-bit range, and `valid` is randomly dropped. Directed cases pin the nibble-carry, byte-carry and zero boundaries, and cover a write back to the operand register itself.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 6;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int OP_W    = 3;
    localparam int NIB_W   = DATA_W / 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_REG = 3'd0,
        OP_ADC_REG = 3'd1,
        OP_ADD_IMM = 3'd2,
        OP_AND_REG = 3'd3,
        OP_AND_IMM = 3'd4
    } op_e;

    // What the execute logic asks the state holders to do this cycle
    typedef struct packed {
        word_t result;
        logic  c_new;
        logic  dc_new;
        logic  z_new;
        logic  upd_carry;   // C and DC written
        logic  upd_zero;    // Z written
        logic  acc_we;
        logic  rf_we;
    } exec_t;

    typedef struct packed {
        word_t sum;
        logic  c;
        logic  dc;
    } add_t;

    function automatic add_t add_with_flags(word_t a, word_t b, logic cin);
        add_t r;
        logic [DATA_W:0] full;
        logic [NIB_W:0]  low;
        full  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        low   = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
        r.sum = full[DATA_W-1:0];
        r.c   = full[DATA_W];
        r.dc  = low[NIB_W];
        return r;
    endfunction

    function automatic logic is_reg_form(logic [OP_W-1:0] code);
        return (code == OP_ADD_REG) || (code == OP_ADC_REG) || (code == OP_AND_REG);
    endfunction

    function automatic logic is_defined(logic [OP_W-1:0] code);
        return code <= OP_AND_IMM;
    endfunction

endpackage

// File: rtl/acc_alu_regfile.sv
module acc_alu_regfile
    import acc_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t waddr,
    input  word_t wdata,
    input  addr_t ra_addr,
    output word_t ra_data,
    input  addr_t rb_addr,
    output word_t rb_data
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

    // A register not addressed by a write keeps its value
    AST_RF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!we || waddr != rb_addr) |=> $stable(rb_data) || (rb_addr != $past(rb_addr)))
        else $error("file register changed without write"); // R2

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
    import acc_alu_pkg::*;
(
    input  logic                valid,
    input  logic [OP_W-1:0]     op,
    input  logic                dst_sel,
    input  word_t               acc_q,
    input  word_t               reg_q,
    input  word_t               imm,
    input  logic                c_q,
    output exec_t               x
);

    add_t  adder;
    word_t opnd;
    logic  cin;
    logic  is_add;
    logic  is_and;
    logic  to_reg;
    logic  live;

    always_comb begin
        live   = valid && is_defined(op);
        is_add = (op == OP_ADD_REG) || (op == OP_ADC_REG) || (op == OP_ADD_IMM);
        is_and = (op == OP_AND_REG) || (op == OP_AND_IMM);
        opnd   = ((op == OP_ADD_IMM) || (op == OP_AND_IMM)) ? imm : reg_q;
        cin    = (op == OP_ADC_REG) ? c_q : 1'b0;
        adder  = add_with_flags(acc_q, opnd, cin);
        to_reg = is_reg_form(op) && dst_sel;

        x           = '0;
        x.result    = is_and ? (acc_q & opnd) : adder.sum;
        x.c_new     = adder.c;
        x.dc_new    = adder.dc;
        x.z_new     = (x.result == '0);
        x.upd_carry = live && is_add;
        x.upd_zero  = live;
        x.rf_we     = live && to_reg;
        x.acc_we    = live && !to_reg;
    end

endmodule

// File: rtl/acc_alu_state.sv
module acc_alu_state
    import acc_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  exec_t x,
    input  logic  valid,
    input  logic  is_and_op,
    output word_t acc_q,
    output logic  c_q,
    output logic  dc_q,
    output logic  z_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            c_q   <= 1'b0;
            dc_q  <= 1'b0;
            z_q   <= 1'b0;
        end else begin
            if (x.acc_we)    acc_q <= x.result;
            if (x.upd_carry) begin
                c_q  <= x.c_new;
                dc_q <= x.dc_new;
            end
            if (x.upd_zero)  z_q  <= x.z_new;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (acc_q == '0) && !c_q && !dc_q && !z_q)
        else $error("reset left state set"); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(acc_q) && $stable(c_q) && $stable(dc_q) && $stable(z_q))
        else $error("state moved while idle"); // R2

    AST_AND_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (valid && is_and_op) |=> $stable(c_q) && $stable(dc_q))
        else $error("AND touched carry flags"); // R6

    AST_ZERO_TRACKS_ACC: assert property (@(posedge clk) disable iff (rst)
        x.acc_we |=> (z_q == (acc_q == '0)))
        else $error("Z disagrees with accumulator"); // R3

endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
    import acc_alu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic [2:0]    op,
    input  logic [AW-1:0] reg_addr,
    input  logic          dst_sel,
    input  logic [DW-1:0] imm,
    input  logic [AW-1:0] obs_addr,
    output logic [DW-1:0] obs_data,
    output logic [DW-1:0] acc,
    output logic          flag_c,
    output logic          flag_dc,
    output logic          flag_z
);

    word_t rf_rd;
    word_t acc_q;
    logic  c_q, dc_q, z_q;
    exec_t x;
    logic  is_and_op;
    logic  is_imm_op;

    assign is_and_op = (op == OP_AND_REG) || (op == OP_AND_IMM);
    assign is_imm_op = (op == OP_ADD_IMM) || (op == OP_AND_IMM);

    acc_alu_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (x.rf_we),
        .waddr   (reg_addr),
        .wdata   (x.result),
        .ra_addr (reg_addr),
        .ra_data (rf_rd),
        .rb_addr (obs_addr),
        .rb_data (obs_data)
    );

    acc_alu_exec u_exec (
        .valid   (valid),
        .op      (op),
        .dst_sel (dst_sel),
        .acc_q   (acc_q),
        .reg_q   (rf_rd),
        .imm     (imm),
        .c_q     (c_q),
        .x       (x)
    );

    acc_alu_state u_state (
        .clk       (clk),
        .rst       (rst),
        .x         (x),
        .valid     (valid),
        .is_and_op (is_and_op),
        .acc_q     (acc_q),
        .c_q       (c_q),
        .dc_q      (dc_q),
        .z_q       (z_q)
    );

    assign acc     = acc_q;
    assign flag_c  = c_q;
    assign flag_dc = dc_q;
    assign flag_z  = z_q;

    AST_IMM_NO_FILE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (valid && is_imm_op) |-> !x.rf_we)
        else $error("immediate op wrote the file"); // R5

    AST_UNDEF_NOP: assert property (@(posedge clk) disable iff (rst)
        (op > 3'd4) |=> $stable(acc) && $stable(flag_c) && $stable(flag_dc) && $stable(flag_z))
        else $error("undefined code changed state"); // R9

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (rst)
        !(x.rf_we && x.acc_we))
        else $error("two destinations written"); // R7

endmodule

// File: tb/sim_acc_alu_top.sv
module sim_acc_alu_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       valid;
    logic [2:0] op;
    logic [5:0] reg_addr;
    logic       dst_sel;
    logic [7:0] imm;
    logic [5:0] obs_addr;
    logic [7:0] obs_data;
    logic [7:0] acc;
    logic       flag_c, flag_dc, flag_z;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] m_reg [64];
    logic [7:0] m_acc;
    logic       m_c, m_dc, m_z;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu_top u0 (
        .clk(clk), .rst(rst), .valid(valid), .op(op), .reg_addr(reg_addr),
        .dst_sel(dst_sel), .imm(imm), .obs_addr(obs_addr), .obs_data(obs_data),
        .acc(acc), .flag_c(flag_c), .flag_dc(flag_dc), .flag_z(flag_z)
    );

    // Reference model step, written from the requirements
    task automatic model(input bit v, input logic [2:0] o, input logic [5:0] a,
                         input bit d, input logic [7:0] i);
        logic [7:0] src, res;
        logic [8:0] s9;
        logic [4:0] s5;
        bit cin, wr_reg;
        if (!v || o > 3'd4) return;                       // R2, R9
        src = (o == 3'd2 || o == 3'd4) ? i : m_reg[a];
        cin = (o == 3'd1) ? m_c : 1'b0;                   // R4
        s9  = {1'b0, m_acc} + {1'b0, src} + {8'd0, cin};
        s5  = {1'b0, m_acc[3:0]} + {1'b0, src[3:0]} + {4'd0, cin};
        res = (o >= 3'd3) ? (m_acc & src) : s9[7:0];      // R6
        if (o <= 3'd2) begin m_c = s9[8]; m_dc = s5[4]; end
        m_z = (res == 8'd0);
        wr_reg = (o == 3'd0 || o == 3'd1 || o == 3'd3) && d;  // R7
        if (wr_reg) m_reg[a] = res; else m_acc = res;
    endtask

    task automatic check(input string req, input logic [7:0] a_got, input logic [7:0] a_exp,
                         input logic [2:0] f_got, input logic [2:0] f_exp,
                         input logic [7:0] r_got, input logic [7:0] r_exp);
        checks++;
        if (a_got !== a_exp || f_got !== f_exp || r_got !== r_exp) begin
            errors++;
            $display("FAIL %s acc=%h/%h flags(c,dc,z)=%b/%b reg=%h/%h (actual/expected)",
                     req, a_got, a_exp, f_got, f_exp, r_got, r_exp);
        end
    endtask

    // Drive at falling edge, let the rising edge act, sample at next falling edge
    task automatic step(input string req, input bit v, input logic [2:0] o,
                        input logic [5:0] a, input bit d, input logic [7:0] i);
        valid = v; op = o; reg_addr = a; dst_sel = d; imm = i; obs_addr = a;
        model(v, o, a, d, i);
        @(negedge clk);
        check(req, acc, m_acc, {flag_c, flag_dc, flag_z}, {m_c, m_dc, m_z},
              obs_data, m_reg[a]);
    endtask

    task automatic load_acc(input logic [7:0] v);
        step("R6", 1, 3'd4, 6'd0, 0, 8'h00);
        step("R5", 1, 3'd2, 6'd0, 0, v);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; valid = 0; op = 0; reg_addr = 0; dst_sel = 0; imm = 0; obs_addr = 0;
        for (int k = 0; k < 64; k++) m_reg[k] = 8'h00;
        m_acc = 0; m_c = 0; m_dc = 0; m_z = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 and R10: everything cleared, file visible through observation port
        for (int k = 0; k < 64; k++) begin
            obs_addr = 6'(k);
            #1;
            check("R1", acc, 8'h00, {flag_c, flag_dc, flag_z}, 3'b000, obs_data, 8'h00);
        end

        // R5: immediate add ignores dst_sel, file untouched
        step("R5", 1, 3'd2, 6'd5, 1, 8'h3C);
        // R7: write to register 5 (reg was 0, so reg := acc)
        step("R7", 1, 3'd0, 6'd5, 1, 8'h00);
        // R3: nibble carry 0x0F + 0x01
        load_acc(8'h0F);
        step("R7", 1, 3'd2, 6'd9, 0, 8'h00);
        step("R3", 1, 3'd0, 6'd9, 1, 8'h00);  // reg9 = 0x0F
        load_acc(8'h01);
        step("R3", 1, 3'd0, 6'd9, 0, 8'h00);  // acc = 0x10, DC=1
        // R3: byte carry and zero 0xFF + 0x01
        load_acc(8'hFF);
        step("R3", 1, 3'd0, 6'd10, 1, 8'h00); // reg10 = 0xFF
        load_acc(8'h01);
        step("R3", 1, 3'd0, 6'd10, 0, 8'h00); // acc=0, C=1, DC=1, Z=1
        // R4: carry-in used
        step("R4", 1, 3'd1, 6'd10, 0, 8'h00); // 0 + FF + 1 = 0, C=1
        // R6: AND to zero keeps C, DC
        step("R6", 1, 3'd4, 6'd0, 0, 8'h00);
        // R8: write back to the operand register uses old value
        load_acc(8'h22);
        step("R8", 1, 3'd0, 6'd10, 1, 8'h00);
        step("R8", 1, 3'd3, 6'd10, 1, 8'h00);
        // R2: valid low changes nothing
        step("R2", 0, 3'd0, 6'd10, 1, 8'h55);
        // R9: undefined codes
        step("R9", 1, 3'd5, 6'd10, 1, 8'h55);
        step("R9", 1, 3'd7, 6'd10, 0, 8'hAA);

        // Random mix
        for (int n = 0; n < 2000; n++) begin
            logic [2:0] o;
            o = 3'($urandom);
            step((o == 3'd1) ? "R4" : (o >= 3'd5) ? "R9" : "R8",
                 ($urandom % 8) != 0, o, 6'($urandom), 1'($urandom), 8'($urandom));
        end

        // Final sweep of the whole file through the observation port (R10)
        for (int k = 0; k < 64; k++) begin
            obs_addr = 6'(k);
            #1;
            check("R10", acc, m_acc, {flag_c, flag_dc, flag_z}, {m_c, m_dc, m_z},
                  obs_data, m_reg[k]);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule